// File: doc/BRIEF.md
# Speculative receive word buffer

This block holds received frames in a circular store of 32-bit words. The receive engine writes each frame into the store while the frame is still arriving. A frame begins with four header words and is followed by its payload words. All of these words go to a speculative position just ahead of the committed write pointer. The reader sees them only once the engine signals that the frame is valid. If the engine aborts the frame, or the store runs out of room, the speculative words are discarded and the committed state is left as it was.

The engine sends one-cycle strobes: a start-of-frame pulse that captures the timestamp, a header strobe, a payload strobe carrying one word, a commit strobe and an abort strobe. The host side reads the word at the read pointer and moves the pointer on with a read strobe. The host also sees the status: capacity, full, empty, the number of stored frames, free words, both pointer positions and a sticky overrun flag.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the buffer is empty and not full. The frame count is 0, free words equal DEPTH, both positions are 0, overrun is 0, and the size output equals DEPTH (default 32).
- R2: A header strobe writes four words at the speculative position, in this order.
  - Word 0: DLC in bits 3:0, remote flag in bit 4, extended-identifier flag in bit 5, flexible-rate format flag in bit 6, rate-switch flag in bit 7, error-state flag in bit 8, and zero in the other bits.
  - Word 1: the 29-bit identifier in bits 28:0.
  - Words 2 and 3: the low and high halves of the timestamp captured by the last start-of-frame pulse.
- R3: Each payload strobe appends its word after the words already written for the frame. Until the commit, the strobe changes neither empty, free words, the write position nor the frame count.
- R4: A commit after an accepted header advances the write position by the number of words written, modulo DEPTH. It lowers free words by the same number and adds one to the frame count.
- R5: An abort discards the current frame. The write position and free words do not change, and the next frame is written to the same words.
- R6: A read strobe on a non-empty buffer advances the read position by one, modulo DEPTH, and the read data then shows the next stored word. A read strobe on an empty buffer changes nothing.
- R7: The frame count drops by one when the last word of a frame is read. A frame occupies 4 + ceil(bytes/4) words, where bytes is 0 for a remote frame without the flexible-rate flag. Otherwise bytes equals the DLC for DLC 0 to 8. Above 8, bytes is 8 without the flag, and with the flag DLC 9 to 15 give 12, 16, 20, 24, 32, 48 and 64.
- R8: A header or payload word that does not fit into DEPTH minus the committed words sets overrun. It also drops the frame, so that the following payload strobes and the commit have no effect. Overrun stays set until the clear input is pulsed.
- R9: Full is 1 exactly when the committed words equal DEPTH. Full and empty are never 1 together, and both positions wrap to 0 after DEPTH-1.
- R10: A commit or payload strobe with no accepted header since the last commit or abort has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_pulse | input | 1 | Start of frame, captures ts_in |
| ts_in | input | 64 | Free-running timestamp |
| meta_store | input | 1 | Header strobe |
| id_in | input | 29 | Received identifier |
| dlc_in | input | 4 | Received length code |
| ext_id_in | input | 1 | Extended identifier flag |
| fd_frame_in | input | 1 | Flexible-rate format flag |
| rtr_in | input | 1 | Remote frame flag |
| brs_in | input | 1 | Rate-switch flag |
| esi_in | input | 1 | Error-state flag |
| data_store | input | 1 | Payload strobe |
| data_word | input | 32 | Payload word, first byte in bits 31:24 |
| frame_valid | input | 1 | Commit strobe |
| frame_abort | input | 1 | Abort strobe |
| ovr_clear | input | 1 | Clears the overrun flag |
| rd_strobe | input | 1 | Host read advance |
| rd_data | output | 32 | Word at the read position |
| buf_size | output | 13 | Capacity in words |
| full | output | 1 | No free word |
| empty | output | 1 | No committed word |
| msg_count | output | 11 | Stored frames |
| free_words | output | 13 | Free committed words |
| rd_pos | output | 12 | Read position |
| wr_pos | output | 12 | Committed write position |
| overrun | output | 1 | Sticky overflow flag |

## Verification
Random frames with random length codes, with and without the flexible-rate flag, exercise the DLC-to-length mapping. They tell a correct word layout apart from shifted or truncated payloads. Mixing commits with aborts at random separates real rollback from partial commits. Interleaved random drains make the pointers wrap at different offsets. Directed cases fill the buffer exactly with minimum-size frames to show full, and run an oversized frame into a nearly full buffer to show the overrun drop. They also send stray commits and payload words without a header.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;

    localparam int WORD_W    = 32;
    localparam int HDR_WORDS = 4;

    // header word 0 field positions
    localparam int F_RTR = 4;
    localparam int F_EXT = 5;
    localparam int F_FD  = 6;
    localparam int F_BRS = 7;
    localparam int F_ESI = 8;

    function automatic logic [WORD_W-1:0] pack_fmt(
        input logic [3:0] dlc,
        input logic       rtr,
        input logic       ext,
        input logic       fd,
        input logic       brs,
        input logic       esi
    );
        logic [WORD_W-1:0] w;
        w        = '0;
        w[3:0]   = dlc;
        w[F_RTR] = rtr;
        w[F_EXT] = ext;
        w[F_FD]  = fd;
        w[F_BRS] = brs;
        w[F_ESI] = esi;
        return w;
    endfunction

    function automatic logic [6:0] payload_bytes(
        input logic [3:0] dlc,
        input logic       fd,
        input logic       rtr
    );
        logic [6:0] n;
        if (rtr && !fd)          n = 7'd0;
        else if (dlc <= 4'd8)    n = {3'd0, dlc};
        else if (!fd)            n = 7'd8;
        else begin
            case (dlc)
                4'd9:    n = 7'd12;
                4'd10:   n = 7'd16;
                4'd11:   n = 7'd20;
                4'd12:   n = 7'd24;
                4'd13:   n = 7'd32;
                4'd14:   n = 7'd48;
                default: n = 7'd64;
            endcase
        end
        return n;
    endfunction

    // total words a stored frame occupies, decoded from its header word 0
    function automatic logic [4:0] frame_words(input logic [WORD_W-1:0] w0);
        logic [6:0] nb;
        logic [6:0] nw;
        nb = payload_bytes(w0[3:0], w0[F_FD], w0[F_RTR]);
        nw = (nb + 7'd3) >> 2;
        return 5'(HDR_WORDS) + nw[4:0];
    endfunction

endpackage

// File: rtl/rxfb_mem.sv
module rxfb_mem #(
    parameter  int DEPTH = 32,
    parameter  int LANES = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic [LANES-1:0]            we,
    input  logic [LANES-1:0][AW-1:0]    waddr,
    input  logic [LANES-1:0][31:0]      wdata,
    input  logic [AW-1:0]               raddr,
    output logic [31:0]                 rdata
);

    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (we[l]) mem_q[waddr[l]] <= wdata[l];
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/rxfb_writer.sv
module rxfb_writer #(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sof_pulse,
    input  logic [63:0]          ts_in,
    input  logic                 meta_store,
    input  logic [31:0]          fmt_word,
    input  logic [31:0]          id_word,
    input  logic                 data_store,
    input  logic [31:0]          data_word,
    input  logic                 frame_valid,
    input  logic                 frame_abort,
    input  logic                 ovr_clear,
    input  logic [CW-1:0]        used,
    output logic [3:0]           mem_we,
    output logic [3:0][AW-1:0]   mem_addr,
    output logic [3:0][31:0]     mem_wdata,
    output logic [AW-1:0]        wr_ptr,
    output logic                 commit,
    output logic [CW-1:0]        commit_len,
    output logic                 overrun
);

    typedef struct packed {
        logic [63:0]   ts;
        logic [AW-1:0] wr_ptr;
        logic [CW-1:0] spec_len;
        logic          open;
        logic          drop;
        logic          ovr;
    } wst_t;

    wst_t          q, d;
    logic [CW-1:0] room;
    logic          meta_sel;
    logic [CW-1:0] base_off;

    function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input logic [CW:0] b);
        logic [CW+1:0] s;
        s = (CW+2)'(a) + (CW+2)'(b);
        if (s >= (CW+2)'(DEPTH)) s = s - (CW+2)'(DEPTH);
        return s[AW-1:0];
    endfunction

    always_comb begin
        d          = q;
        mem_we     = '0;
        commit     = 1'b0;
        commit_len = q.spec_len;
        meta_sel   = 1'b0;
        room       = CW'(DEPTH) - used;
        if (ovr_clear) d.ovr = 1'b0;
        if (sof_pulse) d.ts  = ts_in;
        if (frame_abort) begin
            d.open     = 1'b0;
            d.drop     = 1'b0;
            d.spec_len = '0;
        end else if (frame_valid) begin
            if (q.open && !q.drop) begin
                commit   = 1'b1;
                d.wr_ptr = wrap_add(q.wr_ptr, (CW+1)'(q.spec_len));
            end
            d.open     = 1'b0;
            d.drop     = 1'b0;
            d.spec_len = '0;
        end else if (meta_store) begin
            if (room >= CW'(4)) begin
                meta_sel   = 1'b1;
                mem_we     = 4'hF;
                d.open     = 1'b1;
                d.drop     = 1'b0;
                d.spec_len = CW'(4);
            end else begin
                d.ovr      = 1'b1;
                d.drop     = 1'b1;
                d.open     = 1'b0;
                d.spec_len = '0;
            end
        end else if (data_store && q.open) begin
            if (room > q.spec_len) begin
                mem_we[0]  = 1'b1;
                d.spec_len = q.spec_len + CW'(1);
            end else begin
                d.ovr      = 1'b1;
                d.drop     = 1'b1;
                d.open     = 1'b0;
                d.spec_len = '0;
            end
        end
    end

    assign base_off = meta_sel ? '0 : q.spec_len;

    for (genvar l = 0; l < 4; l++) begin : g_lane
        assign mem_addr[l] = wrap_add(q.wr_ptr, (CW+1)'(base_off) + (CW+1)'(l));
    end

    assign mem_wdata[0] = meta_sel ? fmt_word : data_word;
    assign mem_wdata[1] = id_word;
    assign mem_wdata[2] = q.ts[31:0];
    assign mem_wdata[3] = q.ts[63:32];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign wr_ptr  = q.wr_ptr;
    assign overrun = q.ovr;

endmodule

// File: rtl/rxfb_reader.sv
module rxfb_reader
    import rxfb_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_strobe,
    input  logic           empty,
    input  logic [31:0]    head_word,
    output logic [AW-1:0]  rd_ptr,
    output logic           rd_fire,
    output logic           frame_done
);

    typedef struct packed {
        logic [AW-1:0] rd_ptr;
        logic [4:0]    left;
    } rst_t;

    rst_t q, d;

    always_comb begin
        d          = q;
        rd_fire    = rd_strobe && !empty;
        frame_done = 1'b0;
        if (rd_fire) begin
            d.rd_ptr = (q.rd_ptr == AW'(DEPTH - 1)) ? '0 : q.rd_ptr + AW'(1);
            if (q.left == 5'd0) begin
                d.left = frame_words(head_word) - 5'd1;
            end else begin
                if (q.left == 5'd1) frame_done = 1'b1;
                d.left = q.left - 5'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_ptr = q.rd_ptr;

endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf
    import rxfb_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sof_pulse,
    input  logic [63:0] ts_in,
    input  logic        meta_store,
    input  logic [28:0] id_in,
    input  logic [3:0]  dlc_in,
    input  logic        ext_id_in,
    input  logic        fd_frame_in,
    input  logic        rtr_in,
    input  logic        brs_in,
    input  logic        esi_in,
    input  logic        data_store,
    input  logic [31:0] data_word,
    input  logic        frame_valid,
    input  logic        frame_abort,
    input  logic        ovr_clear,
    input  logic        rd_strobe,
    output logic [31:0] rd_data,
    output logic [12:0] buf_size,
    output logic        full,
    output logic        empty,
    output logic [10:0] msg_count,
    output logic [12:0] free_words,
    output logic [11:0] rd_pos,
    output logic [11:0] wr_pos,
    output logic        overrun
);

    typedef struct packed {
        logic [CW-1:0] used;
        logic [10:0]   msgs;
    } occ_t;

    occ_t                q, d;
    logic [3:0]          mem_we;
    logic [3:0][AW-1:0]  mem_addr;
    logic [3:0][31:0]    mem_wdata;
    logic [AW-1:0]       wr_ptr;
    logic [AW-1:0]       rd_ptr;
    logic                commit;
    logic [CW-1:0]       commit_len;
    logic                rd_fire;
    logic                frame_done;
    logic [31:0]         fmt_word;
    logic [31:0]         id_word;

    assign fmt_word = pack_fmt(dlc_in, rtr_in, ext_id_in, fd_frame_in, brs_in, esi_in);
    assign id_word  = {3'b000, id_in};

    rxfb_writer #(.DEPTH(DEPTH)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_pulse   (sof_pulse),
        .ts_in       (ts_in),
        .meta_store  (meta_store),
        .fmt_word    (fmt_word),
        .id_word     (id_word),
        .data_store  (data_store),
        .data_word   (data_word),
        .frame_valid (frame_valid),
        .frame_abort (frame_abort),
        .ovr_clear   (ovr_clear),
        .used        (q.used),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .wr_ptr      (wr_ptr),
        .commit      (commit),
        .commit_len  (commit_len),
        .overrun     (overrun)
    );

    rxfb_mem #(.DEPTH(DEPTH), .LANES(4)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    rxfb_reader #(.DEPTH(DEPTH)) u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_strobe  (rd_strobe),
        .empty      (empty),
        .head_word  (rd_data),
        .rd_ptr     (rd_ptr),
        .rd_fire    (rd_fire),
        .frame_done (frame_done)
    );

    always_comb begin
        d      = q;
        d.used = q.used + (commit ? commit_len : CW'(0)) - CW'(rd_fire);
        d.msgs = q.msgs + 11'(commit) - 11'(frame_done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_size   = 13'(DEPTH);
    assign empty      = (q.used == '0);
    assign full       = (q.used == CW'(DEPTH));
    assign free_words = 13'(DEPTH) - 13'(q.used);
    assign msg_count  = q.msgs;
    assign rd_pos     = 12'(rd_ptr);
    assign wr_pos     = 12'(wr_ptr);

endmodule

// File: rtl/rx_frame_buf_chk.sv
module rx_frame_buf_chk #(
    parameter int DEPTH = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_valid,
    input logic        frame_abort,
    input logic        rd_strobe,
    input logic        ovr_clear,
    input logic        full,
    input logic        empty,
    input logic [10:0] msg_count,
    input logic [12:0] free_words,
    input logic [11:0] rd_pos,
    input logic [11:0] wr_pos,
    input logic        overrun
);

    assert_full_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_rd_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !empty) |=>
        rd_pos == (($past(rd_pos) == 12'(DEPTH - 1)) ? 12'd0 : $past(rd_pos) + 12'd1));

    assert_rd_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && empty) |=> $stable(rd_pos));

    assert_abort_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_abort && !frame_valid) |=> $stable(wr_pos));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clear) |=> overrun);

    assert_count_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_count == 11'd0) |-> empty);

    assert_free_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !rd_strobe) |=> $stable(free_words));

endmodule

bind rx_frame_buf rx_frame_buf_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_frame_buf_tb.sv
module rx_frame_buf_tb;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof_pulse, meta_store, data_store, frame_valid, frame_abort, ovr_clear, rd_strobe;
    logic [63:0] ts_in;
    logic [28:0] id_in;
    logic [3:0]  dlc_in;
    logic        ext_id_in, fd_frame_in, rtr_in, brs_in, esi_in;
    logic [31:0] data_word;
    logic [31:0] rd_data;
    logic [12:0] buf_size, free_words;
    logic        full, empty, overrun;
    logic [10:0] msg_count;
    logic [11:0] rd_pos, wr_pos;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] exp_q[$];
    int          fr_q[$];
    int          wr_m = 0;
    int          rd_m = 0;
    int          msg_m = 0;
    bit          ovr_m = 0;

    always #5 clk = ~clk;

    rx_frame_buf #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_bytes(input logic [3:0] dlc, input logic fd, input logic rtr);
        if (rtr && !fd) return 0;
        if (dlc <= 8) return int'(dlc);
        if (!fd) return 8;
        case (dlc)
            9: return 12;
            10: return 16;
            11: return 20;
            12: return 24;
            13: return 32;
            14: return 48;
            default: return 64;
        endcase
    endfunction

    function automatic logic [31:0] exp_fmt(input logic [3:0] dlc, input logic rtr, ext, fd, brs, esi);
        return {23'd0, esi, brs, fd, ext, rtr, dlc};
    endfunction

    task automatic check_state(input string req);
        chk(wr_pos == 12'(wr_m), {req, " wr_pos"}, wr_pos, wr_m);
        chk(rd_pos == 12'(rd_m), {req, " rd_pos"}, rd_pos, rd_m);
        chk(free_words == 13'(DEPTH - exp_q.size()), {req, " free"}, free_words, DEPTH - exp_q.size());
        chk(msg_count == 11'(msg_m), {req, " count"}, msg_count, msg_m);
        chk(empty == (exp_q.size() == 0), {req, " empty"}, empty, exp_q.size() == 0);
        chk(full == (exp_q.size() == DEPTH), "R9 full", full, exp_q.size() == DEPTH);
        chk(overrun == ovr_m, {req, " overrun"}, overrun, ovr_m);
    endtask

    task automatic send_frame(input logic [28:0] id, input logic [3:0] dlc,
                              input logic fd, input logic rtr, input logic ext,
                              input logic brs, input logic esi, input bit do_abort);
        logic [63:0] ts;
        logic [31:0] tmp[$];
        logic [31:0] w;
        int          nb;
        int          nw;
        bit          drop;
        int          used0;
        ts    = {$urandom, $urandom};
        nb    = exp_bytes(dlc, fd, rtr);
        nw    = (nb + 3) / 4;
        drop  = 0;
        used0 = exp_q.size();
        ts_in = ts; sof_pulse = 1'b1;
        @(negedge clk);
        sof_pulse = 1'b0; ts_in = {$urandom, $urandom};
        id_in = id; dlc_in = dlc; fd_frame_in = fd; rtr_in = rtr;
        ext_id_in = ext; brs_in = brs; esi_in = esi; meta_store = 1'b1;
        @(negedge clk);
        meta_store = 1'b0;
        if (used0 + 4 > DEPTH) begin
            ovr_m = 1; drop = 1;
        end else begin
            tmp.push_back(exp_fmt(dlc, rtr, ext, fd, brs, esi));
            tmp.push_back({3'd0, id});
            tmp.push_back(ts[31:0]);
            tmp.push_back(ts[63:32]);
        end
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int b = 0; b < 4; b++) begin
                if (k * 4 + b < nb) w[31 - 8*b -: 8] = 8'($urandom);
            end
            data_word = w; data_store = 1'b1;
            @(negedge clk);
            data_store = 1'b0;
            if (!drop) begin
                if (used0 + tmp.size() + 1 > DEPTH) begin
                    ovr_m = 1; drop = 1; tmp.delete();
                end else begin
                    tmp.push_back(w);
                end
            end
            if ($urandom % 2 == 0) @(negedge clk);
        end
        // R3: nothing visible before commit
        check_state("R3");
        if (do_abort) begin
            frame_abort = 1'b1;
            @(negedge clk);
            frame_abort = 1'b0;
            check_state("R5");
        end else begin
            frame_valid = 1'b1;
            @(negedge clk);
            frame_valid = 1'b0;
            if (!drop) begin
                foreach (tmp[i]) exp_q.push_back(tmp[i]);
                fr_q.push_back(tmp.size());
                wr_m = (wr_m + tmp.size()) % DEPTH;
                msg_m++;
                check_state("R4");
            end else begin
                check_state("R8");
            end
        end
    endtask

    task automatic read_words(input int n);
        for (int i = 0; i < n; i++) begin
            if (exp_q.size() == 0) break;
            chk(rd_data == exp_q[0], "R2 word", rd_data, exp_q[0]);
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            void'(exp_q.pop_front());
            rd_m = (rd_m + 1) % DEPTH;
            fr_q[0] = fr_q[0] - 1;
            if (fr_q[0] == 0) begin
                void'(fr_q.pop_front());
                msg_m--;
            end
            chk(rd_pos == 12'(rd_m), "R6 rd_pos", rd_pos, rd_m);
            chk(msg_count == 11'(msg_m), "R7 count", msg_count, msg_m);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17C3));
        rst_n = 1'b0;
        sof_pulse = 0; meta_store = 0; data_store = 0; frame_valid = 0;
        frame_abort = 0; ovr_clear = 0; rd_strobe = 0;
        ts_in = '0; id_in = '0; dlc_in = '0; ext_id_in = 0; fd_frame_in = 0;
        rtr_in = 0; brs_in = 0; esi_in = 0; data_word = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(buf_size == 13'(DEPTH), "R1 size", buf_size, DEPTH);
        check_state("R1");

        // R10 stray commit and payload word
        frame_valid = 1'b1; @(negedge clk); frame_valid = 1'b0;
        data_word = 32'hDEADBEEF; data_store = 1'b1; @(negedge clk); data_store = 1'b0;
        frame_valid = 1'b1; @(negedge clk); frame_valid = 1'b0;
        check_state("R10");

        // R6 read on empty
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        check_state("R6");

        // R2 layout, explicit header word 0
        send_frame(29'h1ABCDEF3, 4'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(rd_data == 32'h0000_0125, "R2 fmt", rd_data, 32'h125);
        read_words(exp_q.size());

        // R5 abort then reuse of the same words
        send_frame(29'h55, 4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        send_frame(29'h66, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        read_words(exp_q.size());

        // R9 exact fill with minimum frames, then drain with wrap
        for (int i = 0; i < DEPTH / 4; i++)
            send_frame(29'(i), 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(full == 1'b1, "R9 full set", full, 1);
        read_words(DEPTH);
        check_state("R9");

        // R8 overrun on oversized frame, sticky, then cleared
        send_frame(29'h7, 4'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        send_frame(29'h8, 4'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(overrun == 1'b1, "R8 set", overrun, 1);
        read_words(exp_q.size());
        send_frame(29'h9, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(overrun == 1'b1, "R8 sticky", overrun, 1);
        ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0; ovr_m = 0;
        check_state("R8");
        read_words(exp_q.size());

        // random mix, R7 length decoding across codes
        for (int it = 0; it < 120; it++) begin
            logic fd;
            fd = 1'($urandom);
            send_frame(29'($urandom), 4'($urandom), fd, fd ? 1'b0 : 1'($urandom % 4 == 0),
                       1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
            if (overrun) begin
                ovr_clear = 1'b1; @(negedge clk); ovr_clear = 1'b0; ovr_m = 0;
            end
            read_words(int'($urandom % (exp_q.size() + 1)));
        end
        read_words(exp_q.size());
        check_state("R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule